// File: doc/BRIEF.md
# Outstanding Line Miss Table with Register Scoreboard

This block lets a cache that does not block on a miss keep several line misses in flight at once. Each of its slots follows one missing line. For every word of that line, a slot records which destination register is waiting for the word, if any. A load that misses either opens a fresh slot and sends one line request to memory, or joins the slot already open for the same line without a second request. Either way, the load's destination register is marked empty in a full/empty scoreboard, and the load can leave the pipeline at once.

Decode asks the scoreboard whether a source register is ready and holds the instruction while the answer is no. When memory returns a line for a slot, all registers waiting on that slot are written in the same cycle and marked full, and the slot is released. Cache hits pass straight through: they use no slot and send no memory request. When the request cannot be taken, the block raises a stall to the requester.

Top module: `miss_status_table`

## Requirements
- R1: After reset no slot is open, every register reads ready on `qry_ready`, `mem_req_valid` is 0 and `wb_valid` is 0.
- R2: A miss (`req_valid`=1, `req_hit`=0) to a line held by no slot takes the lowest-numbered free slot. `req_stall` stays 0. In the next cycle only, `mem_req_valid` is 1, with `mem_req_line` equal to the line and `mem_req_id` equal to the slot number.
- R3: A miss to a line that an open slot already holds joins that slot. `req_stall` stays 0 and no memory request follows.
- R4: From the cycle after an accepted miss, its destination register reads not ready on `qry_ready`, and it stays not ready until the slot's line returns.
- R5: When every slot is open, a miss to a line held by none of them raises `req_stall` in the same cycle. It sends no request and leaves the destination register ready.
- R6: A miss that joins a slot whose word (`req_word`) is already claimed by an earlier miss raises `req_stall` and changes nothing.
- R7: A miss whose destination register already reads not ready raises `req_stall` and sends no request.
- R8: During a cycle with `fill_valid`=1 for an open slot `fill_id`, `wb_valid` bit w is 1 exactly for the claimed words. Field w of `wb_reg` (bits w*REG_W upward) carries the waiting register, and `wb_data` equals `fill_data`, word w at bits w*DATA_W upward. From the next cycle those registers read ready and the slot is free for a new line.
- R9: A hit (`req_valid`=1, `req_hit`=1) never stalls, sends no memory request and leaves its destination register ready.
- R10: A miss to the line of the slot being refilled in that same cycle raises `req_stall`, and the refill still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load lookup result is presented |
| req_hit | input | 1 | 1 = the load hit in the cache |
| req_line | input | LINE_W | Line address of the load |
| req_word | input | log2(WORDS) | Word index within the line |
| req_dst | input | log2(NUM_REGS) | Destination register of the load |
| req_stall | output | 1 | The miss cannot be accepted this cycle |
| qry_reg | input | log2(NUM_REGS) | Register asked about by decode |
| qry_ready | output | 1 | 1 = that register holds its value (full) |
| mem_req_valid | output | 1 | One-cycle line request to memory |
| mem_req_line | output | LINE_W | Line address requested |
| mem_req_id | output | log2(ENTRIES) | Slot that will receive the line |
| fill_valid | input | 1 | A returned line is presented |
| fill_id | input | log2(ENTRIES) | Slot the returned line belongs to |
| fill_data | input | WORDS*DATA_W | Returned line, word w at bits w*DATA_W |
| wb_valid | output | WORDS | Per-word register write enable |
| wb_reg | output | WORDS*REG_W | Per-word destination register |
| wb_data | output | WORDS*DATA_W | Per-word write data |

## Verification
`req_stall` and the write-back outputs follow the inputs of the same cycle. The bench drives every input on the falling edge and reads these outputs 2 ns later, before the rising edge that would commit the request. The memory request and the scoreboard state change at that rising edge, so the bench reads `mem_req_valid`, `mem_req_id` and `qry_ready` 2 ns after the next falling edge. It also confirms that the request pulse is gone one cycle later. Refused requests are checked the same way: no request pulse appears and the destination register still reads ready.

// File: rtl/mst_pkg.sv
package mst_pkg;

  // Outcome of the request presented in the current cycle
  typedef enum logic [2:0] {
    REQ_NONE  = 3'd0,
    REQ_HIT   = 3'd1,
    REQ_ALLOC = 3'd2,
    REQ_MERGE = 3'd3,
    REQ_STALL = 3'd4
  } req_kind_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mst_entry.sv
module mst_entry
  import mst_pkg::*;
#(
  parameter int unsigned LINE_W = 16,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned REG_W  = 5,
  localparam int unsigned WI_W  = idx_width(WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_en,
  input  logic [LINE_W-1:0]            alloc_line,
  input  logic                         claim_en,
  input  logic [WI_W-1:0]              claim_word,
  input  logic [REG_W-1:0]             claim_reg,
  input  logic                         free_en,
  output logic                         valid_o,
  output logic [LINE_W-1:0]            line_o,
  output logic [WORDS-1:0]             claimed_o,
  output logic [WORDS-1:0][REG_W-1:0]  regs_o
);

  logic                        valid_q, valid_n;
  logic [LINE_W-1:0]           line_q, line_n;
  logic [WORDS-1:0]            claimed_q, claimed_n;
  logic [WORDS-1:0][REG_W-1:0] regs_q, regs_n;
  logic                        upd_en;

  assign upd_en = alloc_en | claim_en | free_en;

  always_comb begin
    valid_n   = valid_q;
    line_n    = line_q;
    claimed_n = claimed_q;
    regs_n    = regs_q;
    if (free_en) begin
      valid_n   = 1'b0;
      claimed_n = '0;
    end
    if (alloc_en) begin
      valid_n   = 1'b1;
      line_n    = alloc_line;
      claimed_n = '0;
    end
    if (claim_en) begin
      claimed_n[claim_word] = 1'b1;
      regs_n[claim_word]    = claim_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      line_q    <= '0;
      claimed_q <= '0;
      regs_q    <= '0;
    end else if (upd_en) begin
      valid_q   <= valid_n;
      line_q    <= line_n;
      claimed_q <= claimed_n;
      regs_q    <= regs_n;
    end
  end

  assign valid_o   = valid_q;
  assign line_o    = line_q;
  assign claimed_o = claimed_q;
  assign regs_o    = regs_q;

  // R3: an open slot stays open until its line returns
  a_r3_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !free_en) |=> valid_q);

  // R6: a joining miss never lands on a word that is already claimed
  a_r6_no_reclaim: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && !alloc_en) |-> !claimed_q[claim_word]);

endmodule

// File: rtl/mst_lookup.sv
module mst_lookup
  import mst_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned LINE_W  = 16,
  localparam int unsigned ID_W   = idx_width(ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ENTRIES-1:0]                ent_valid,
  input  logic [ENTRIES-1:0][LINE_W-1:0]    ent_line,
  input  logic [LINE_W-1:0]                 req_line,
  output logic                              match_any,
  output logic [ID_W-1:0]                   match_idx,
  output logic                              free_any,
  output logic [ID_W-1:0]                   free_idx
);

  logic [ENTRIES-1:0] match_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = ent_valid[i] && (ent_line[i] == req_line);
  end

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i])  match_idx = ID_W'(i);
      if (!ent_valid[i]) free_idx  = ID_W'(i);
    end
  end

  assign match_any = |match_vec;
  assign free_any  = ~&ent_valid;

  // R3: one line is held by at most one slot
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

endmodule

// File: rtl/mst_scoreboard.sv
module mst_scoreboard
  import mst_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned REG_W   = idx_width(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [REG_W-1:0]    set_reg,
  input  logic [NUM_REGS-1:0] clr_mask,
  input  logic [REG_W-1:0]    rd_a_reg,
  output logic                rd_a_busy,
  input  logic [REG_W-1:0]    rd_b_reg,
  output logic                rd_b_busy
);

  logic [NUM_REGS-1:0] busy_q, busy_n, set_mask;
  logic                upd_en;

  always_comb begin
    set_mask = '0;
    if (set_en) set_mask[set_reg] = 1'b1;
    busy_n = (busy_q & ~clr_mask) | set_mask;
  end

  assign upd_en = set_en | (|clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= '0;
    else if (upd_en) busy_q <= busy_n;
  end

  assign rd_a_busy = busy_q[rd_a_reg];
  assign rd_b_busy = busy_q[rd_b_reg];

  // R4: an accepted miss leaves its register empty
  a_r4_mark_empty: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> busy_q[$past(set_reg)]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    // R8: a written-back register is full in the next cycle
    a_r8_mark_full: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[g] && !(set_en && set_reg == REG_W'(g))) |=> !busy_q[g]);
  end

endmodule

// File: rtl/miss_status_table.sv
module miss_status_table
  import mst_pkg::*;
#(
  parameter int unsigned ENTRIES  = 4,
  parameter int unsigned WORDS    = 4,
  parameter int unsigned LINE_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ID_W    = idx_width(ENTRIES),
  localparam int unsigned WI_W    = idx_width(WORDS),
  localparam int unsigned REG_W   = idx_width(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_hit,
  input  logic [LINE_W-1:0]       req_line,
  input  logic [WI_W-1:0]         req_word,
  input  logic [REG_W-1:0]        req_dst,
  output logic                    req_stall,
  input  logic [REG_W-1:0]        qry_reg,
  output logic                    qry_ready,
  output logic                    mem_req_valid,
  output logic [LINE_W-1:0]       mem_req_line,
  output logic [ID_W-1:0]         mem_req_id,
  input  logic                    fill_valid,
  input  logic [ID_W-1:0]         fill_id,
  input  logic [WORDS*DATA_W-1:0] fill_data,
  output logic [WORDS-1:0]        wb_valid,
  output logic [WORDS*REG_W-1:0]  wb_reg,
  output logic [WORDS*DATA_W-1:0] wb_data
);

  logic [ENTRIES-1:0]                         ent_valid;
  logic [ENTRIES-1:0][LINE_W-1:0]             ent_line;
  logic [ENTRIES-1:0][WORDS-1:0]              ent_claimed;
  logic [ENTRIES-1:0][WORDS-1:0][REG_W-1:0]   ent_regs;

  logic            match_any, free_any;
  logic [ID_W-1:0] match_idx, free_idx, target_idx;
  logic            dst_busy, qry_busy;
  logic            is_miss, fill_ok, fill_race, word_taken;
  req_kind_e       kind;
  logic            accept, do_alloc;
  logic [NUM_REGS-1:0] clr_mask;

  logic              mreq_valid_q, mreq_valid_n;
  logic [LINE_W-1:0] mreq_line_q;
  logic [ID_W-1:0]   mreq_id_q;

  mst_lookup #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_valid (ent_valid),
    .ent_line  (ent_line),
    .req_line  (req_line),
    .match_any (match_any),
    .match_idx (match_idx),
    .free_any  (free_any),
    .free_idx  (free_idx)
  );

  assign is_miss    = req_valid && !req_hit;
  assign fill_ok    = fill_valid && ent_valid[fill_id];
  assign fill_race  = fill_ok && match_any && (match_idx == fill_id);
  assign word_taken = ent_claimed[match_idx][req_word];

  always_comb begin
    kind = REQ_NONE;
    if (req_valid && req_hit) begin
      kind = REQ_HIT;
    end else if (is_miss) begin
      if (dst_busy)             kind = REQ_STALL;
      else if (match_any) begin
        if (word_taken || fill_race) kind = REQ_STALL;
        else                         kind = REQ_MERGE;
      end
      else if (free_any)        kind = REQ_ALLOC;
      else                      kind = REQ_STALL;
    end
  end

  assign accept     = (kind == REQ_ALLOC) || (kind == REQ_MERGE);
  assign do_alloc   = (kind == REQ_ALLOC);
  assign req_stall  = (kind == REQ_STALL);
  assign target_idx = match_any ? match_idx : free_idx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    mst_entry #(.LINE_W(LINE_W), .WORDS(WORDS), .REG_W(REG_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (do_alloc && (free_idx == ID_W'(i))),
      .alloc_line (req_line),
      .claim_en   (accept && (target_idx == ID_W'(i))),
      .claim_word (req_word),
      .claim_reg  (req_dst),
      .free_en    (fill_ok && (fill_id == ID_W'(i))),
      .valid_o    (ent_valid[i]),
      .line_o     (ent_line[i]),
      .claimed_o  (ent_claimed[i]),
      .regs_o     (ent_regs[i])
    );
  end

  // Write-back of a returned line
  for (genvar w = 0; w < WORDS; w++) begin : g_wb
    assign wb_valid[w]                  = fill_ok && ent_claimed[fill_id][w];
    assign wb_reg[w*REG_W +: REG_W]     = ent_regs[fill_id][w];
    assign wb_data[w*DATA_W +: DATA_W]  = fill_data[w*DATA_W +: DATA_W];
  end

  always_comb begin
    clr_mask = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (wb_valid[w]) clr_mask[ent_regs[fill_id][w]] = 1'b1;
    end
  end

  mst_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (accept),
    .set_reg   (req_dst),
    .clr_mask  (clr_mask),
    .rd_a_reg  (qry_reg),
    .rd_a_busy (qry_busy),
    .rd_b_reg  (req_dst),
    .rd_b_busy (dst_busy)
  );

  assign qry_ready = !qry_busy;

  // Memory request register
  assign mreq_valid_n = do_alloc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mreq_valid_q <= 1'b0;
    else        mreq_valid_q <= mreq_valid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mreq_line_q <= '0;
      mreq_id_q   <= '0;
    end else if (do_alloc) begin
      mreq_line_q <= req_line;
      mreq_id_q   <= free_idx;
    end
  end

  assign mem_req_valid = mreq_valid_q;
  assign mem_req_line  = mreq_line_q;
  assign mem_req_id    = mreq_id_q;

  // R9: a hit never produces a memory request
  a_r9_hit_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hit) |=> !mem_req_valid);

  // R5: full table and a new line means stall
  a_r5_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (is_miss && !match_any && (&ent_valid)) |-> req_stall);

  // R10: a miss racing its own slot's refill is refused
  a_r10_race_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (is_miss && fill_ok && match_any && (match_idx == fill_id)) |-> req_stall);

  // R2: each request pulse lasts one cycle unless a new line was taken
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !do_alloc) |=> !mem_req_valid);

endmodule

// File: tb/miss_status_table_tb.sv
module miss_status_table_tb;

  localparam int LINE_W = 16;
  localparam int DATA_W = 16;
  localparam int WORDS  = 4;
  localparam int REG_W  = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_hit;
  logic [LINE_W-1:0] req_line;
  logic [1:0] req_word;
  logic [REG_W-1:0] req_dst;
  logic req_stall;
  logic [REG_W-1:0] qry_reg;
  logic qry_ready;
  logic mem_req_valid;
  logic [LINE_W-1:0] mem_req_line;
  logic [1:0] mem_req_id;
  logic fill_valid;
  logic [1:0] fill_id;
  logic [WORDS*DATA_W-1:0] fill_data;
  logic [WORDS-1:0] wb_valid;
  logic [WORDS*REG_W-1:0] wb_reg;
  logic [WORDS*DATA_W-1:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  miss_status_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_hit(req_hit), .req_line(req_line),
    .req_word(req_word), .req_dst(req_dst), .req_stall(req_stall),
    .qry_reg(qry_reg), .qry_ready(qry_ready),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line), .mem_req_id(mem_req_id),
    .fill_valid(fill_valid), .fill_id(fill_id), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qry(input string tag, input int r, input bit exp_ready);
    qry_reg = REG_W'(r);
    #1;
    chk(tag, qry_ready, exp_ready);
  endtask

  // Present a request (and optionally a refill) at the falling edge
  task automatic drive(input bit hit, input int line, input int word, input int dst,
                       input bit fv, input int fid);
    @(negedge clk);
    req_valid = 1'b1; req_hit = hit; req_line = LINE_W'(line);
    req_word = 2'(word); req_dst = REG_W'(dst);
    fill_valid = fv; fill_id = 2'(fid);
    #2;
  endtask

  // Remove stimulus at the next falling edge, after the rising edge took it
  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_hit = 1'b0; fill_valid = 1'b0;
    #2;
  endtask

  task automatic fill_only(input int fid);
    @(negedge clk);
    fill_valid = 1'b1; fill_id = 2'(fid);
    #2;
  endtask

  task automatic t_reset();
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 stall", req_stall, 0);
    for (int r = 0; r < 32; r++) qry("R1 ready", r, 1);
  endtask

  task automatic t_alloc();
    drive(0, 'h100, 1, 5, 0, 0);
    chk("R2 no stall", req_stall, 0);
    idle();
    chk("R2 req valid", mem_req_valid, 1);
    chk("R2 req line", mem_req_line, 'h100);
    chk("R2 req id", mem_req_id, 0);
    qry("R4 dst empty", 5, 0);
    @(negedge clk); #2;
    chk("R2 pulse ends", mem_req_valid, 0);
    qry("R4 still empty", 5, 0);
  endtask

  task automatic t_merge();
    drive(0, 'h100, 2, 6, 0, 0);
    chk("R3 no stall", req_stall, 0);
    idle();
    chk("R3 no request", mem_req_valid, 0);
    qry("R4 merged dst empty", 6, 0);
  endtask

  task automatic t_word_conflict();
    drive(0, 'h100, 1, 7, 0, 0);
    chk("R6 stall", req_stall, 1);
    idle();
    chk("R6 no request", mem_req_valid, 0);
    qry("R6 dst untouched", 7, 1);
  endtask

  task automatic t_dst_busy();
    drive(0, 'h200, 0, 5, 0, 0);
    chk("R7 stall", req_stall, 1);
    idle();
    chk("R7 no request", mem_req_valid, 0);
  endtask

  task automatic t_hit();
    drive(1, 'h300, 0, 9, 0, 0);
    chk("R9 no stall", req_stall, 0);
    idle();
    chk("R9 no request", mem_req_valid, 0);
    qry("R9 dst ready", 9, 1);
  endtask

  task automatic t_fill();
    fill_data = {16'hD3D3, 16'hC2C2, 16'hB1B1, 16'hA0A0};
    fill_only(0);
    chk("R8 wb_valid", wb_valid, 4'b0110);
    chk("R8 wb_reg w1", wb_reg[1*REG_W +: REG_W], 5);
    chk("R8 wb_reg w2", wb_reg[2*REG_W +: REG_W], 6);
    chk("R8 wb_data w1", wb_data[1*DATA_W +: DATA_W], 'hB1B1);
    chk("R8 wb_data w2", wb_data[2*DATA_W +: DATA_W], 'hC2C2);
    idle();
    chk("R8 wb off", wb_valid, 0);
    qry("R8 reg5 full", 5, 1);
    qry("R8 reg6 full", 6, 1);
    drive(0, 'h100, 0, 13, 0, 0);
    chk("R8 slot reuse no stall", req_stall, 0);
    idle();
    chk("R8 new request after free", mem_req_valid, 1);
    chk("R8 freed slot id", mem_req_id, 0);
  endtask

  task automatic t_full();
    drive(0, 'h200, 0, 10, 0, 0); idle();
    chk("R2 slot1", mem_req_id, 1);
    drive(0, 'h300, 0, 11, 0, 0); idle();
    chk("R2 slot2", mem_req_id, 2);
    drive(0, 'h400, 0, 12, 0, 0); idle();
    chk("R2 slot3", mem_req_id, 3);
    drive(0, 'h500, 0, 14, 0, 0);
    chk("R5 stall", req_stall, 1);
    idle();
    chk("R5 no request", mem_req_valid, 0);
    qry("R5 dst ready", 14, 1);
    fill_data = 64'h1;
    fill_only(2);
    chk("R8 slot2 wb", wb_valid, 4'b0001);
    idle();
    drive(0, 'h500, 0, 14, 0, 0);
    chk("R2 after free no stall", req_stall, 0);
    idle();
    chk("R2 lowest free slot", mem_req_id, 2);
    chk("R2 line", mem_req_line, 'h500);
  endtask

  task automatic t_race();
    fill_data = 64'h77;
    drive(0, 'h200, 3, 15, 1, 1);
    chk("R10 stall", req_stall, 1);
    chk("R10 wb_valid", wb_valid, 4'b0001);
    chk("R10 wb_reg", wb_reg[REG_W-1:0], 10);
    idle();
    chk("R10 no request", mem_req_valid, 0);
    qry("R10 dst ready", 15, 1);
    qry("R10 refill done", 10, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_hit = 0; req_line = '0; req_word = '0; req_dst = '0;
    qry_reg = '0; fill_valid = 0; fill_id = '0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_alloc();
    t_merge();
    t_word_conflict();
    t_dst_busy();
    t_hit();
    t_fill();
    t_full();
    t_race();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule